// File: doc/BRIEF.md
# Boundary-Splitting Word DMA Sequencer

This block accepts one transfer request: a base word address, a starting word offset and a total word count. It splits the request into segments that a 16-bit DMA channel can carry. No segment crosses a 64K-word boundary of the offset, and no segment is longer than 65535 words. For each segment the block computes the register values the channel expects and issues a fixed sequence of one-cycle programming strobes. It then waits for the channel to report completion before it moves on to the next segment.

While it waits, the block watches the channel's done and memory-error flags. A memory error aborts the whole request. A wait that runs past a set number of timer intervals raises a single warning, and the block keeps waiting. A segment whose first and last absolute addresses differ in their bits above the low 16 is refused with an error, and nothing is sent to the channel for it. The memory bus and the plotter side of the channel are outside this block.

Top module: `segDmaSeq`

## Requirements
- R1: Each segment length is the smallest of three values: the words still to send, the words left before the next 64K-word multiple of the current offset, and 65535.
- R2: `segCount` holds the segment length minus one, because the channel moves one word more than its programmed count.
- R3: `segAddrLow` holds bits 15:0 of the segment's absolute word address (base + offset). `segAddrHigh` holds bits 23:16 of the byte address, which is the word address times two.
- R4: Each segment is programmed with four one-cycle strobes on consecutive cycles, in the order `ptrClr`, `doneClr`, `modeSel`, `unmask`. The strobe sequence begins two cycles after the request is accepted or after the previous segment completes.
- R5: After `unmask`, the block waits for `chanDone`. On done, the offset advances by the segment length and the remaining count drops by the same amount. If words remain, the next segment follows.
- R6: `xferDone` pulses for one cycle once the remaining count reaches zero. A request with a zero count pulses `xferDone` on the cycle after acceptance and produces no strobes.
- R7: `chanMemErr` seen during the wait pulses `xferError` on the next cycle and ends the request. It takes priority over a `chanDone` seen in the same cycle.
- R8: A wait that lasts more than WARN_AFTER timer intervals of TIMEOUT_CYCLES cycles each pulses `timeoutWarn` once in that segment, on wait cycle WARN_AFTER+1 times TIMEOUT_CYCLES counted from zero, unless done or error is present in that cycle. The wait then continues.
- R9: If a segment's first and last absolute word addresses differ in bits 23:16, `xferError` pulses and no strobe is issued for that segment.
- R10: `busy` is high from the cycle after acceptance until the cycle after the done or error pulse. `reqValid` is ignored while `busy` is high.
- R11: After reset, `busy`, every strobe, every flag and the segment registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqBase | input | ADDR_W | Absolute base word address |
| reqOffset | input | ADDR_W | Starting word offset from the base |
| reqCount | input | CNT_W | Total words to move |
| chanDone | input | 1 | Channel completion flag |
| chanMemErr | input | 1 | Channel memory-error flag |
| ptrClr | output | 1 | Strobe: clear the channel's byte pointer |
| doneClr | output | 1 | Strobe: clear done and select done-on-complete |
| modeSel | output | 1 | Strobe: keep done-on-complete and stop clearing done |
| unmask | output | 1 | Strobe: release the channel mask and start the segment |
| segAddrLow | output | SEG_W | Low word-address bits of the segment |
| segAddrHigh | output | 8 | High byte of the segment byte address |
| segCount | output | SEG_W | Segment length minus one |
| busy | output | 1 | Request in progress |
| xferDone | output | 1 | One-cycle pulse when the whole request has been sent |
| xferError | output | 1 | One-cycle pulse when the request is aborted |
| timeoutWarn | output | 1 | One-cycle warning that a segment wait ran long |

## Verification
Every output comes from registered state. Strobes, flags and segment registers therefore change one clock after the input that causes them, so acceptance shows `busy` one cycle later and the first `ptrClr` two cycles later. Done or error seen during the wait shows up as the next state one cycle later. The timeout warning is the one output that also depends on the current done and error inputs. The bench keeps a behavioural model that is advanced on each rising edge from the same inputs. On each falling edge it compares all outputs against that model, and it changes stimulus only after the comparison. Directed counts of segments and of the lengths issued cover the splitting cases across boundaries.

// File: rtl/segDmaPkg.sv
package segDmaPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SEG, ST_PCLR, ST_DCLR, ST_MODE,
    ST_GO, ST_WAIT, ST_ADV, ST_DONE, ST_FAIL
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic capture;  // register the segment values
    logic advance;  // step offset and remaining count
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic zeroReq;   // request count is zero
    logic boundErr;  // segment would cross upper-half boundary
    logic lastSeg;   // current segment finishes the request
  } dpStat_t;

endpackage

// File: rtl/segDmaDatapath.sv
module segDmaDatapath
  import segDmaPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 24,
  parameter int SEG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [CNT_W-1:0]  reqCount,
  output dpStat_t           stat,
  output logic [SEG_W-1:0]  segAddrLow,
  output logic [7:0]        segAddrHigh,
  output logic [SEG_W-1:0]  segCount
);

  localparam int BW = ADDR_W + 1;                          // byte-address width
  localparam logic [CNT_W-1:0] WINDOW = CNT_W'(1) << SEG_W; // words per boundary window
  localparam logic [CNT_W-1:0] CAP    = WINDOW - CNT_W'(1); // longest segment

  logic [ADDR_W-1:0] baseQ, offQ;
  logic [CNT_W-1:0]  remQ;
  logic [SEG_W-1:0]  segLenQ;

  logic [CNT_W-1:0]  toBound, lenA, lenB;
  logic [SEG_W-1:0]  segLenN;
  logic [ADDR_W-1:0] startAddr, endAddr;
  logic [BW-1:0]     byteAddr;

  always_comb begin
    toBound   = WINDOW - CNT_W'(offQ[SEG_W-1:0]);
    lenA      = (remQ < toBound) ? remQ : toBound;
    lenB      = (lenA > CAP) ? CAP : lenA;
    segLenN   = SEG_W'(lenB);
    startAddr = baseQ + offQ;
    endAddr   = startAddr + ADDR_W'(segLenN) - ADDR_W'(1);
    byteAddr  = {startAddr, 1'b0};
  end

  assign stat.zeroReq  = (reqCount == '0);
  assign stat.boundErr = (startAddr[ADDR_W-1:SEG_W] != endAddr[ADDR_W-1:SEG_W]);
  assign stat.lastSeg  = (remQ == CNT_W'(segLenQ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ       <= '0;
      offQ        <= '0;
      remQ        <= '0;
      segLenQ     <= '0;
      segAddrLow  <= '0;
      segAddrHigh <= '0;
      segCount    <= '0;
    end else begin
      if (ctl.load) begin
        baseQ <= reqBase;
        offQ  <= reqOffset;
        remQ  <= reqCount;
      end
      if (ctl.capture) begin
        segLenQ     <= segLenN;
        segAddrLow  <= startAddr[SEG_W-1:0];
        segAddrHigh <= byteAddr[SEG_W+7:SEG_W];
        segCount    <= segLenN - SEG_W'(1);
      end
      if (ctl.advance) begin
        offQ <= offQ + ADDR_W'(segLenQ);
        remQ <= remQ - CNT_W'(segLenQ);
      end
    end
  end

endmodule

// File: rtl/segDmaControl.sv
module segDmaControl
  import segDmaPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int WARN_AFTER     = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  dpStat_t stat,
  input  logic    chanDone,
  input  logic    chanMemErr,
  output dpCtl_t  ctl,
  output logic    ptrClr,
  output logic    doneClr,
  output logic    modeSel,
  output logic    unmask,
  output logic    busy,
  output logic    xferDone,
  output logic    xferError,
  output logic    timeoutWarn
);

  localparam int TW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam int IW = $clog2(WARN_AFTER + 2);
  localparam logic [TW-1:0] TMR_LAST = TW'(TIMEOUT_CYCLES - 1);
  localparam logic [IW-1:0] IVL_MAX  = IW'(WARN_AFTER + 1);

  seqState_e stateQ, stateN;
  logic [TW-1:0] tmrQ;
  logic [IW-1:0] ivlQ;
  logic          warnedQ;
  logic          warnNow;

  always_comb begin
    stateN      = stateQ;
    ctl.load    = 1'b0;
    ctl.capture = 1'b0;
    ctl.advance = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (reqValid) begin
        ctl.load = 1'b1;
        stateN   = stat.zeroReq ? ST_DONE : ST_SEG;
      end
      ST_SEG: begin
        ctl.capture = !stat.boundErr;
        stateN      = stat.boundErr ? ST_FAIL : ST_PCLR;
      end
      ST_PCLR: stateN = ST_DCLR;
      ST_DCLR: stateN = ST_MODE;
      ST_MODE: stateN = ST_GO;
      ST_GO:   stateN = ST_WAIT;
      ST_WAIT: begin
        if (chanMemErr)    stateN = ST_FAIL;
        else if (chanDone) stateN = ST_ADV;
      end
      ST_ADV: begin
        ctl.advance = 1'b1;
        stateN      = stat.lastSeg ? ST_DONE : ST_SEG;
      end
      ST_DONE: stateN = ST_IDLE;
      ST_FAIL: stateN = ST_IDLE;
      default: stateN = ST_IDLE;
    endcase
  end

  assign warnNow = (stateQ == ST_WAIT) && (ivlQ == IVL_MAX) && !warnedQ
                   && !chanDone && !chanMemErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      tmrQ    <= '0;
      ivlQ    <= '0;
      warnedQ <= 1'b0;
    end else begin
      stateQ <= stateN;
      if (stateQ == ST_GO) begin
        tmrQ    <= '0;
        ivlQ    <= '0;
        warnedQ <= 1'b0;
      end else if (stateQ == ST_WAIT) begin
        if (tmrQ == TMR_LAST) begin
          tmrQ <= '0;
          if (ivlQ != IVL_MAX) ivlQ <= ivlQ + IW'(1);
        end else begin
          tmrQ <= tmrQ + TW'(1);
        end
        if (warnNow) warnedQ <= 1'b1;
      end
    end
  end

  assign ptrClr      = (stateQ == ST_PCLR);
  assign doneClr     = (stateQ == ST_DCLR);
  assign modeSel     = (stateQ == ST_MODE);
  assign unmask      = (stateQ == ST_GO);
  assign busy        = (stateQ != ST_IDLE);
  assign xferDone    = (stateQ == ST_DONE);
  assign xferError   = (stateQ == ST_FAIL);
  assign timeoutWarn = warnNow;

endmodule

// File: rtl/segDmaSeq.sv
module segDmaSeq
  import segDmaPkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int CNT_W          = 24,
  parameter int SEG_W          = 16,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int WARN_AFTER     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              chanDone,
  input  logic              chanMemErr,
  output logic              ptrClr,
  output logic              doneClr,
  output logic              modeSel,
  output logic              unmask,
  output logic [SEG_W-1:0]  segAddrLow,
  output logic [7:0]        segAddrHigh,
  output logic [SEG_W-1:0]  segCount,
  output logic              busy,
  output logic              xferDone,
  output logic              xferError,
  output logic              timeoutWarn
);

  dpCtl_t  ctl;
  dpStat_t stat;

  segDmaControl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .WARN_AFTER    (WARN_AFTER)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .stat       (stat),
    .chanDone   (chanDone),
    .chanMemErr (chanMemErr),
    .ctl        (ctl),
    .ptrClr     (ptrClr),
    .doneClr    (doneClr),
    .modeSel    (modeSel),
    .unmask     (unmask),
    .busy       (busy),
    .xferDone   (xferDone),
    .xferError  (xferError),
    .timeoutWarn(timeoutWarn)
  );

  segDmaDatapath #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .SEG_W (SEG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqBase    (reqBase),
    .reqOffset  (reqOffset),
    .reqCount   (reqCount),
    .stat       (stat),
    .segAddrLow (segAddrLow),
    .segAddrHigh(segAddrHigh),
    .segCount   (segCount)
  );

endmodule

// File: rtl/segDmaSeqChk.sv
module segDmaSeqChk #(
  parameter int SEG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             ptrClr,
  input logic             doneClr,
  input logic             modeSel,
  input logic             unmask,
  input logic [SEG_W-1:0] segAddrLow,
  input logic [SEG_W-1:0] segCount,
  input logic             busy,
  input logic             xferDone,
  input logic             xferError,
  input logic             timeoutWarn
);

  // R4: at most one programming strobe per cycle
  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ptrClr, doneClr, modeSel, unmask}));

  // R4: strobe order
  p_ptr_then_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    ptrClr |=> doneClr);
  p_done_then_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneClr |=> modeSel);
  p_mode_then_go_r4: assert property (@(posedge clk) disable iff (!rstN)
    modeSel |=> unmask);

  // R2: programmed count never exceeds the cap minus one
  p_count_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    unmask |-> (segCount != {SEG_W{1'b1}}));

  // R9: an issued segment stays inside one upper-half window
  p_window_r9: assert property (@(posedge clk) disable iff (!rstN)
    unmask |-> ((SEG_W+1)'(segAddrLow) + (SEG_W+1)'(segCount)) < ((SEG_W+1)'(1) << SEG_W));

  // R6 / R7: done and error never together
  p_done_err_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(xferDone && xferError));

  // R8: warning is a single-cycle pulse
  p_warn_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutWarn |=> !timeoutWarn);

  // R10: request ends one cycle after completion
  p_idle_after_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone || xferError) |=> !busy);

  // R5: channel only started while a request is active
  p_go_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    unmask |-> busy);

endmodule

bind segDmaSeq segDmaSeqChk #(.SEG_W(SEG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ptrClr     (ptrClr),
  .doneClr    (doneClr),
  .modeSel    (modeSel),
  .unmask     (unmask),
  .segAddrLow (segAddrLow),
  .segCount   (segCount),
  .busy       (busy),
  .xferDone   (xferDone),
  .xferError  (xferError),
  .timeoutWarn(timeoutWarn)
);

// File: tb/segDmaSeq_bench.sv
`timescale 1ns/1ps
module segDmaSeq_bench;

  localparam int TICK = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [23:0] reqBase = '0, reqOffset = '0, reqCount = '0;
  logic        chanDone = 1'b0, chanMemErr = 1'b0;
  logic        ptrClr, doneClr, modeSel, unmask, busy, xferDone, xferError, timeoutWarn;
  logic [15:0] segAddrLow, segCount;
  logic [7:0]  segAddrHigh;

  always #2.5 clk = ~clk;

  segDmaSeq #(.TIMEOUT_CYCLES(TICK), .WARN_AFTER(3)) u_segDmaSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBase(reqBase),
    .reqOffset(reqOffset), .reqCount(reqCount), .chanDone(chanDone),
    .chanMemErr(chanMemErr), .ptrClr(ptrClr), .doneClr(doneClr),
    .modeSel(modeSel), .unmask(unmask), .segAddrLow(segAddrLow),
    .segAddrHigh(segAddrHigh), .segCount(segCount), .busy(busy),
    .xferDone(xferDone), .xferError(xferError), .timeoutWarn(timeoutWarn)
  );

  int vectors = 0, fails = 0, cycles = 0;

  task automatic cmp(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int     mSt = 0;  // 0 idle 1 seg 2 ptr 3 dclr 4 mode 5 go 6 wait 7 adv 8 done 9 fail
  longint mBase, mOff, mRem, mLen;
  longint eLow = 0, eHigh = 0, eCnt = 0;
  int     mTmr, mIvl;
  bit     mWarned;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; eLow = 0; eHigh = 0; eCnt = 0; mTmr = 0; mIvl = 0; mWarned = 0;
    end else begin
      case (mSt)
        0: if (reqValid) begin
             mBase = reqBase; mOff = reqOffset; mRem = reqCount;
             mSt = (reqCount == 0) ? 8 : 1;
           end
        1: begin
             longint len, st, en;
             len = mRem;
             if (65536 - (mOff % 65536) < len) len = 65536 - (mOff % 65536);
             if (len > 65535) len = 65535;
             st = (mBase + mOff) % (64'd1 << 24);
             en = (st + len - 1) % (64'd1 << 24);
             if ((st >> 16) != (en >> 16)) mSt = 9;
             else begin
               eLow = st % 65536; eHigh = ((st * 2) >> 16) % 256; eCnt = len - 1;
               mLen = len; mSt = 2;
             end
           end
        2, 3, 4: mSt++;
        5: begin mTmr = 0; mIvl = 0; mWarned = 0; mSt = 6; end
        6: begin
             bit wn;
             wn = (mIvl == 4) && !mWarned && !chanDone && !chanMemErr;
             if (chanMemErr) mSt = 9;
             else if (chanDone) mSt = 7;
             if (mTmr == TICK - 1) begin mTmr = 0; if (mIvl < 4) mIvl++; end
             else mTmr++;
             if (wn) mWarned = 1;
           end
        7: begin
             mOff = (mOff + mLen) % (64'd1 << 24);
             mRem = mRem - mLen;
             mSt = (mRem == 0) ? 8 : 1;
           end
        default: mSt = 0;
      endcase
    end
  end

  // ---------------- channel responder ----------------
  int  chanDelay = 3;
  bit  errMode = 0;
  int  chanCnt = -1;
  int  segSeen = 0, warnSeen = 0;
  longint segLens[$];

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      // compare all outputs against the model, before any input changes
      cmp("R10 busy", busy, mSt != 0);
      cmp("R6 xferDone", xferDone, mSt == 8);
      cmp("R7/R9 xferError", xferError, mSt == 9);
      cmp("R4 ptrClr", ptrClr, mSt == 2);
      cmp("R4 doneClr", doneClr, mSt == 3);
      cmp("R4 modeSel", modeSel, mSt == 4);
      cmp("R4 unmask", unmask, mSt == 5);
      cmp("R8 timeoutWarn", timeoutWarn,
          (mSt == 6) && (mIvl == 4) && !mWarned && !chanDone && !chanMemErr);
      cmp("R3 segAddrLow", segAddrLow, eLow);
      cmp("R3 segAddrHigh", segAddrHigh, eHigh);
      cmp("R2 segCount", segCount, eCnt);
      if (timeoutWarn) warnSeen++;
    end
    // channel behaviour
    if (doneClr) chanDone = 1'b0;
    if (unmask) begin
      chanCnt = chanDelay; chanMemErr = 1'b0; segSeen++;
      segLens.push_back(longint'(segCount) + 1);
    end else if (chanCnt > 0) chanCnt--;
    else if (chanCnt == 0) begin
      if (errMode) chanMemErr = 1'b1; else chanDone = 1'b1;
      chanCnt = -1;
    end
  end

  task automatic runReq(longint b, longint o, longint c, int dly, bit em, bit glitch);
    @(negedge clk);
    chanDelay = dly; errMode = em; segSeen = 0; warnSeen = 0; segLens.delete();
    chanMemErr = 1'b0;
    reqBase = 24'(b); reqOffset = 24'(o); reqCount = 24'(c); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (glitch) begin
      @(negedge clk);
      reqBase = 24'h123456; reqOffset = 24'h00FFFF; reqCount = 24'h7; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    cmp("R11 busy", busy, 0);
    cmp("R11 strobes", {ptrClr, doneClr, modeSel, unmask}, 0);
    cmp("R11 flags", {xferDone, xferError, timeoutWarn}, 0);
    cmp("R11 segCount", segCount, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R6: zero-length request
    runReq(0, 24'h100, 0, 3, 0, 0);
    cmp("R6 zero count strobes", segSeen, 0);

    // R5 / R10: short transfer with a stray request while busy
    runReq(24'h020000, 24'h10, 5, 3, 0, 1);
    cmp("R10 single segment despite stray request", segSeen, 1);

    // R1: crossing a 64K-word window splits in two
    runReq(0, 24'h00FFF0, 24'h30, 2, 0, 0);
    cmp("R5 split segments", segSeen, 2);
    if (segLens.size() == 2) begin
      cmp("R1 first length", segLens[0], 24'h10);
      cmp("R1 second length", segLens[1], 24'h20);
    end

    // R1: cap at 65535 words
    runReq(24'h300000, 0, 24'h20000, 1, 0, 0);
    cmp("R5 capped segments", segSeen, 4);
    if (segLens.size() == 4) begin
      cmp("R1 cap length", segLens[0], 65535);
      cmp("R1 remainder length", segLens[1], 1);
    end

    // R9: unaligned base makes the absolute range cross
    runReq(24'h008000, 0, 24'h9000, 2, 0, 0);
    cmp("R9 no strobes on violation", segSeen, 0);

    // R7: memory error aborts
    runReq(0, 24'h40, 24'h20, 4, 1, 0);
    cmp("R7 aborted after one segment", segSeen, 1);

    // R8: long wait warns exactly once
    runReq(24'h001000, 24'h5, 24'h8, 4 * TICK + 20, 0, 0);
    cmp("R8 single warning", warnSeen, 1);

    // R3: odd high byte placement
    runReq(24'h7F0000, 24'h8000, 3, 1, 0, 0);
    cmp("R3 high byte", segAddrHigh, 8'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule